// File: doc/BRIEF.md
# Flash Bank Erase and Program Sequencer

This block drives a byte-wide flash device that is controlled by command bytes and reports progress through a status byte. It erases one bank or programs one bank from a source buffer, with no help from software. Each flash operation is followed by status polling until the device reports ready. A cleanup pair of commands then returns the device to array-read mode. A full read-back pass compares every byte of the bank with what it should now hold.

A pulse on `erase_start_i` or `prog_start_i` starts an operation. `busy_o` stays high until the read-back pass ends. `error_o` and `timeout_o` then describe the result and hold it until the next start. The flash bus and the source-buffer port both use one-cycle read latency. The source buffer is read one byte at a time through its own address and strobe.

Top module: `flash_bank_seq`

## Requirements
- R1: An erase begins with a write of 0x20 and then a write of 0xD0, both to flash address 0.
- R2: Each status poll is a write of 0x70 to address 0, followed by one read of address 0. The device counts as ready when bit 7 of the returned status byte is 1.
- R3: Bytes are programmed in ascending address order. For each byte there is a write of 0x40 to the byte address, then at least HOLD_CYCLES cycles with no flash strobe, then a write of the source byte to the same address, then polling.
- R4: When an operation ends (completed, aborted or timed out), the block writes 0x50 and then 0xFF to address 0, and then starts the read-back pass.
- R5: If POLL_LIMIT status reads in a row all return bit 7 clear, `timeout_o` is set and the programming of any remaining bytes is skipped.
- R6: If a ready status byte has any bit of mask 0x38 set, `error_o` is set and the programming of any remaining bytes is skipped.
- R7: The read-back pass reads every address of the bank in ascending order. Any byte that differs from 0xFF (after an erase) or from the source byte (after a program) sets `error_o`.
- R8: `busy_o` rises in the cycle after an accepted start and falls when the read-back pass ends. Start pulses that arrive while busy are ignored. If both starts arrive together, the erase is the one accepted.
- R9: After reset, `busy_o`, `error_o` and `timeout_o` are low. Both flags are cleared when a new operation is accepted, and they hold their final values after it ends.
- R10: Flash and source read data are sampled in the cycle after their read strobe. Flash write and read strobes are never active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| erase_start_i | input | 1 | Request a bank erase |
| prog_start_i | input | 1 | Request a bank program |
| flash_addr_o | output | AW | Flash byte address, AW = log2(BANK_BYTES) |
| flash_wdata_o | output | 8 | Flash write data or command byte |
| flash_we_o | output | 1 | Flash write strobe |
| flash_re_o | output | 1 | Flash read strobe |
| flash_rdata_i | input | 8 | Flash read data, valid in the cycle after the read strobe |
| src_addr_o | output | AW | Source buffer address |
| src_rd_o | output | 1 | Source buffer read strobe |
| src_data_i | input | 8 | Source data, valid in the cycle after the read strobe |
| busy_o | output | 1 | An operation is in progress |
| error_o | output | 1 | Status error or read-back mismatch in the last operation |
| timeout_o | output | 1 | Poll limit reached in the last operation |

## Verification
The bench checks the complete flash bus trace against an expected trace. This catches a command byte that is wrong, sent to the wrong address or sent in the wrong order. It also catches a cleanup pair that is missing, and a read-back pass that skips addresses. Two aborts are tested: a device that hangs at a chosen byte, and one that reports an error bit at a chosen byte. Programming must stop at exactly that byte. A design that kept going would produce extra setup writes, and one that gave up too early would leave the trace short. A program run without a prior erase leaves bits the device cannot raise, so only the read-back pass can raise the error. A start pulse in the middle of an operation, and two starts arriving together, show whether starts are ignored while busy and whether erase wins.

// File: rtl/fbs_pkg.sv
package fbs_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ER_SETUP,
    ST_ER_CONF,
    ST_PG_SETUP,
    ST_PG_HOLD,
    ST_PG_DATA,
    ST_POLL_CMD,
    ST_POLL_RD,
    ST_POLL_CHK,
    ST_CLR,
    ST_RST,
    ST_VF_RD,
    ST_VF_CHK
  } seq_state_e;

  localparam logic [7:0] CMD_ERASE_SETUP = 8'h20;
  localparam logic [7:0] CMD_ERASE_GO    = 8'hD0;
  localparam logic [7:0] CMD_PROG_SETUP  = 8'h40;
  localparam logic [7:0] CMD_STATUS      = 8'h70;
  localparam logic [7:0] CMD_CLR_STATUS  = 8'h50;
  localparam logic [7:0] CMD_READ_ARRAY  = 8'hFF;
  localparam int unsigned STAT_READY_BIT = 7;
  localparam logic [7:0] STAT_ERR_MASK   = 8'h38;
  localparam logic [7:0] ERASED_BYTE     = 8'hFF;

endpackage

// File: rtl/fbs_limit_ctr.sv
module fbs_limit_ctr #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic hit_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  assign hit_o = (cnt_q == CW'(LIMIT - 1));

  // holds at the limit so a caller that keeps incrementing cannot wrap
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (inc_i && !hit_o)   cnt_q <= cnt_q + 1'b1;
  end

  // bounds both the poll count (R5) and the hold time (R3)
  assert_cnt_in_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(LIMIT));

endmodule

// File: rtl/fbs_addr_ctr.sv
module fbs_addr_ctr #(
  parameter int unsigned BANK_BYTES = 64,
  localparam int unsigned AW = $clog2(BANK_BYTES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [AW-1:0] addr_o,
  output logic          last_o
);
  logic [AW-1:0] addr_q;

  assign addr_o = addr_q;
  assign last_o = (addr_q == AW'(BANK_BYTES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (clr_i)  addr_q <= '0;
    else if (inc_i)  addr_q <= addr_q + 1'b1;
  end

  assert_no_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |-> !last_o);

endmodule

// File: rtl/flash_bank_seq.sv
module flash_bank_seq
  import fbs_pkg::*;
#(
  parameter int unsigned BANK_BYTES  = 8192,
  parameter int unsigned HOLD_CYCLES = 125,
  parameter int unsigned POLL_LIMIT  = 1000000,
  localparam int unsigned AW = $clog2(BANK_BYTES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          erase_start_i,
  input  logic          prog_start_i,
  output logic [AW-1:0] flash_addr_o,
  output logic [7:0]    flash_wdata_o,
  output logic          flash_we_o,
  output logic          flash_re_o,
  input  logic [7:0]    flash_rdata_i,
  output logic [AW-1:0] src_addr_o,
  output logic          src_rd_o,
  input  logic [7:0]    src_data_i,
  output logic          busy_o,
  output logic          error_o,
  output logic          timeout_o
);
  localparam int unsigned GW = $clog2(HOLD_CYCLES + 2);

  seq_state_e    state_q, state_d;
  logic          op_erase_q;
  logic          err_q, tmo_q;
  logic [7:0]    data_q;
  logic          src_pend_q;

  logic          byte_clr, byte_inc, byte_last;
  logic [AW-1:0] byte_addr;
  logic          hold_clr, hold_inc, hold_hit;
  logic          poll_clr, poll_inc, poll_hit;
  logic          err_set, tmo_set, start_take;
  logic          stat_ready, stat_bad;
  logic [7:0]    vf_expect;

  fbs_addr_ctr #(.BANK_BYTES(BANK_BYTES)) u_byte_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (byte_clr),
    .inc_i  (byte_inc),
    .addr_o (byte_addr),
    .last_o (byte_last)
  );

  fbs_limit_ctr #(.LIMIT(HOLD_CYCLES)) u_hold_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (hold_clr),
    .inc_i  (hold_inc),
    .hit_o  (hold_hit)
  );

  fbs_limit_ctr #(.LIMIT(POLL_LIMIT)) u_poll_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (poll_clr),
    .inc_i  (poll_inc),
    .hit_o  (poll_hit)
  );

  assign stat_ready = flash_rdata_i[STAT_READY_BIT];
  assign stat_bad   = |(flash_rdata_i & STAT_ERR_MASK);
  assign vf_expect  = op_erase_q ? ERASED_BYTE : src_data_i;

  always_comb begin
    state_d       = state_q;
    flash_addr_o  = '0;
    flash_wdata_o = '0;
    flash_we_o    = 1'b0;
    flash_re_o    = 1'b0;
    src_addr_o    = byte_addr;
    src_rd_o      = 1'b0;
    byte_clr      = 1'b0;
    byte_inc      = 1'b0;
    hold_clr      = 1'b0;
    hold_inc      = 1'b0;
    poll_clr      = 1'b0;
    poll_inc      = 1'b0;
    err_set       = 1'b0;
    tmo_set       = 1'b0;
    start_take    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        byte_clr = 1'b1;
        if (erase_start_i || prog_start_i) begin
          start_take = 1'b1;
          state_d    = erase_start_i ? ST_ER_SETUP : ST_PG_SETUP;
        end
      end
      ST_ER_SETUP: begin
        flash_we_o    = 1'b1;
        flash_wdata_o = CMD_ERASE_SETUP;
        state_d       = ST_ER_CONF;
      end
      ST_ER_CONF: begin
        flash_we_o    = 1'b1;
        flash_wdata_o = CMD_ERASE_GO;
        poll_clr      = 1'b1;
        state_d       = ST_POLL_CMD;
      end
      ST_PG_SETUP: begin
        flash_we_o    = 1'b1;
        flash_addr_o  = byte_addr;
        flash_wdata_o = CMD_PROG_SETUP;
        src_rd_o      = 1'b1;
        hold_clr      = 1'b1;
        state_d       = ST_PG_HOLD;
      end
      ST_PG_HOLD: begin
        hold_inc = 1'b1;
        if (hold_hit) state_d = ST_PG_DATA;
      end
      ST_PG_DATA: begin
        flash_we_o    = 1'b1;
        flash_addr_o  = byte_addr;
        flash_wdata_o = data_q;
        poll_clr      = 1'b1;
        state_d       = ST_POLL_CMD;
      end
      ST_POLL_CMD: begin
        flash_we_o    = 1'b1;
        flash_wdata_o = CMD_STATUS;
        state_d       = ST_POLL_RD;
      end
      ST_POLL_RD: begin
        flash_re_o = 1'b1;
        state_d    = ST_POLL_CHK;
      end
      ST_POLL_CHK: begin
        poll_inc = 1'b1;
        if (stat_ready) begin
          if (stat_bad) begin
            err_set = 1'b1;
            state_d = ST_CLR;
          end else if (op_erase_q || byte_last) begin
            state_d = ST_CLR;
          end else begin
            byte_inc = 1'b1;
            state_d  = ST_PG_SETUP;
          end
        end else if (poll_hit) begin
          tmo_set = 1'b1;
          state_d = ST_CLR;
        end else begin
          state_d = ST_POLL_CMD;
        end
      end
      ST_CLR: begin
        flash_we_o    = 1'b1;
        flash_wdata_o = CMD_CLR_STATUS;
        state_d       = ST_RST;
      end
      ST_RST: begin
        flash_we_o    = 1'b1;
        flash_wdata_o = CMD_READ_ARRAY;
        byte_clr      = 1'b1;
        state_d       = ST_VF_RD;
      end
      ST_VF_RD: begin
        flash_re_o   = 1'b1;
        flash_addr_o = byte_addr;
        src_rd_o     = !op_erase_q;
        state_d      = ST_VF_CHK;
      end
      ST_VF_CHK: begin
        if (flash_rdata_i != vf_expect) err_set = 1'b1;
        if (byte_last) begin
          state_d = ST_IDLE;
        end else begin
          byte_inc = 1'b1;
          state_d  = ST_VF_RD;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      op_erase_q <= 1'b0;
      err_q      <= 1'b0;
      tmo_q      <= 1'b0;
      data_q     <= '0;
      src_pend_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      src_pend_q <= src_rd_o;
      if (src_pend_q) data_q <= src_data_i;
      if (start_take) begin
        op_erase_q <= erase_start_i;
        err_q      <= 1'b0;
        tmo_q      <= 1'b0;
      end else begin
        if (err_set) err_q <= 1'b1;
        if (tmo_set) tmo_q <= 1'b1;
      end
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign error_o   = err_q;
  assign timeout_o = tmo_q;

  // hold-gap checker: cycles since the last program-setup write
  logic [GW-1:0] gap_q;
  logic          setup_seen_q;
  logic          setup_wr;

  assign setup_wr = flash_we_o && (state_q == ST_PG_SETUP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q        <= '0;
      setup_seen_q <= 1'b0;
    end else begin
      if (setup_wr)                       gap_q <= '0;
      else if (gap_q != GW'(HOLD_CYCLES)) gap_q <= gap_q + 1'b1;
      if (setup_wr)        setup_seen_q <= 1'b1;
      else if (flash_we_o) setup_seen_q <= 1'b0;
    end
  end

  assert_hold_gap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flash_we_o && setup_seen_q) |-> (gap_q == GW'(HOLD_CYCLES)));

  assert_excl_strobes_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(flash_we_o && flash_re_o));

  assert_quiet_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!flash_we_o && !flash_re_o && !src_rd_o));

  assert_start_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && (erase_start_i || prog_start_i)) |=> busy_o);

  assert_flags_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (!error_o && !timeout_o));

  assert_tmo_cleanup_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> (flash_we_o && flash_wdata_o == CMD_CLR_STATUS));

  assert_flags_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !(erase_start_i || prog_start_i)) |=> ($stable(error_o) && $stable(timeout_o)));

endmodule

// File: tb/flash_bank_seq_tb.sv
`timescale 1ns/1ps
module flash_bank_seq_tb;
  localparam int BANK = 64;
  localparam int HOLD = 3;
  localparam int PLIM = 8;
  localparam int AW   = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic erase_start = 1'b0, prog_start = 1'b0;
  logic [AW-1:0] f_addr, s_addr;
  logic [7:0] f_wdata;
  logic f_we, f_re, s_rd;
  logic [7:0] rdata_r = 8'h00, sdata_r = 8'h00;
  logic busy, err, tmo;

  always #4 clk = ~clk;

  flash_bank_seq #(.BANK_BYTES(BANK), .HOLD_CYCLES(HOLD), .POLL_LIMIT(PLIM)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .erase_start_i(erase_start), .prog_start_i(prog_start),
    .flash_addr_o(f_addr), .flash_wdata_o(f_wdata),
    .flash_we_o(f_we), .flash_re_o(f_re), .flash_rdata_i(rdata_r),
    .src_addr_o(s_addr), .src_rd_o(s_rd), .src_data_i(sdata_r),
    .busy_o(busy), .error_o(err), .timeout_o(tmo)
  );

  int nchecks = 0, nfails = 0;
  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    nchecks++;
    if (!ok) begin
      nfails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // scoreboard of expected flash bus events
  typedef struct { bit wr; int a; int d; string tag; } item_t;
  item_t exp_q[$];

  task automatic push_w(input int a, input int d, input string tag);
    item_t it; it.wr = 1; it.a = a; it.d = d; it.tag = tag; exp_q.push_back(it);
  endtask
  task automatic push_r(input int a, input string tag);
    item_t it; it.wr = 0; it.a = a; it.d = 0; it.tag = tag; exp_q.push_back(it);
  endtask

  // device model state
  logic [7:0] dev_mem [BANK];
  logic [7:0] src_mem [BANK];
  logic [7:0] pred    [BANK];
  int nbusy = 1, hang_byte = -1, err_byte = -1, pend = 0;
  bit hang_erase = 0, erase_err_en = 0, st_mode = 0, want_data = 0, want_conf = 0, cur_hang = 0;
  logic [7:0] err_bits = 8'h10, cur_err = 8'h00;
  bit last_setup = 0;
  longint setup_cyc = 0;
  bit exp_err, exp_tmo;

  task automatic sb_event(input bit wr, input int a, input int d);
    item_t it;
    if (exp_q.size() == 0) begin
      chk(0, "R4", wr ? "unexpected write" : "unexpected read", a, -1);
      return;
    end
    it = exp_q.pop_front();
    chk(it.wr == wr, it.tag, "event kind", wr, it.wr);
    chk(it.a == a, it.tag, "address", a, it.a);
    if (wr) chk(it.d == d, it.tag, "write data", d, it.d);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (s_rd) sdata_r = src_mem[s_addr];
      if (f_we || f_re) chk(!(f_we && f_re), "R10", "we and re together", 1, 0);
      if (f_we) begin
        sb_event(1, int'(f_addr), int'(f_wdata));
        if (last_setup)
          chk(cyc - setup_cyc >= HOLD + 1, "R3", "setup-to-data gap", int'(cyc - setup_cyc), HOLD + 1);
        last_setup = 0;
        if (want_data) begin
          dev_mem[f_addr] = dev_mem[f_addr] & f_wdata;
          want_data = 0; st_mode = 1; pend = nbusy;
          cur_hang = (hang_byte == int'(f_addr));
          cur_err  = (err_byte == int'(f_addr)) ? err_bits : 8'h00;
        end else begin
          case (f_wdata)
            8'h40: begin want_data = 1; last_setup = 1; setup_cyc = cyc; end
            8'h20: want_conf = 1;
            8'hD0: if (want_conf) begin
              for (int i = 0; i < BANK; i++) dev_mem[i] = 8'hFF;
              want_conf = 0; st_mode = 1; pend = nbusy;
              cur_hang = hang_erase;
              cur_err  = erase_err_en ? err_bits : 8'h00;
            end
            8'h70: st_mode = 1;
            8'h50: cur_err = 8'h00;
            8'hFF: st_mode = 0;
            default: ;
          endcase
        end
      end
      if (f_re) begin
        sb_event(0, int'(f_addr), 0);
        if (st_mode) begin
          if (cur_hang) rdata_r = 8'h00;
          else if (pend > 0) begin pend--; rdata_r = 8'h00; end
          else rdata_r = 8'h80 | cur_err;
        end else rdata_r = dev_mem[f_addr];
      end
    end
  end

  task automatic push_polls(input int n);
    for (int k = 0; k < n; k++) begin push_w(0, 8'h70, "R2"); push_r(0, "R2"); end
  endtask

  task automatic push_tail(input bit chk_src);
    push_w(0, 8'h50, "R4");
    push_w(0, 8'hFF, "R4");
    for (int i = 0; i < BANK; i++) begin
      push_r(i, "R7");
      if (pred[i] != (chk_src ? src_mem[i] : 8'hFF)) exp_err = 1;
    end
  endtask

  task automatic exp_erase();
    exp_err = erase_err_en; exp_tmo = hang_erase;
    push_w(0, 8'h20, "R1"); push_w(0, 8'hD0, "R1");
    push_polls(hang_erase ? PLIM : nbusy + 1);
    for (int i = 0; i < BANK; i++) pred[i] = 8'hFF;
    push_tail(0);
  endtask

  task automatic exp_prog();
    exp_err = 0; exp_tmo = 0;
    for (int i = 0; i < BANK; i++) begin
      push_w(i, 8'h40, "R3"); push_w(i, int'(src_mem[i]), "R3");
      pred[i] = pred[i] & src_mem[i];
      if (hang_byte == i) begin push_polls(PLIM); exp_tmo = 1; break; end
      push_polls(nbusy + 1);
      if (err_byte == i) begin exp_err = 1; break; end
    end
    push_tail(1);
  endtask

  task automatic run_op(input bit er, input bit pr, input int poke, input string tag);
    if (er) exp_erase(); else exp_prog();
    @(negedge clk); erase_start = er; prog_start = pr;
    @(negedge clk); erase_start = 0; prog_start = 0;
    chk(busy == 1, "R8", {tag, " busy after start"}, busy, 1);
    chk(err == 0 && tmo == 0, "R9", {tag, " flags cleared"}, {err, tmo}, 0);
    if (poke > 0) begin
      repeat (poke) @(negedge clk);
      prog_start = 1; @(negedge clk); prog_start = 0;
    end
    while (busy) @(negedge clk);
    chk(err == exp_err, exp_tmo ? "R5" : (er ? "R6" : "R7"), {tag, " error_o"}, err, exp_err);
    chk(tmo == exp_tmo, "R5", {tag, " timeout_o"}, tmo, exp_tmo);
    chk(exp_q.size() == 0, "R4", {tag, " trace complete"}, exp_q.size(), 0);
    exp_q.delete();
    repeat (4) @(negedge clk);
    chk(busy == 0, "R8", {tag, " stays idle"}, busy, 0);
    chk(err == exp_err && tmo == exp_tmo, "R9", {tag, " flags held"}, {err, tmo}, {exp_err, exp_tmo});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchecks++; nfails++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", nfails, nchecks);
    $finish;
  end

  initial begin
    for (int i = 0; i < BANK; i++) begin dev_mem[i] = 8'(i); pred[i] = 8'(i); end
    repeat (3) @(negedge clk);
    chk(busy == 0 && err == 0 && tmo == 0, "R9", "reset outputs", {busy, err, tmo}, 0);
    chk(f_we == 0 && f_re == 0 && s_rd == 0, "R9", "reset strobes", {f_we, f_re, s_rd}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    nbusy = 2; run_op(1, 0, 0, "R1 erase");
    for (int i = 0; i < BANK; i++) src_mem[i] = 8'(i * 7 + 3);
    nbusy = 1; run_op(0, 1, 0, "R3 program");
    for (int i = 0; i < BANK; i++) src_mem[i] = 8'(i) ^ 8'hA5;
    run_op(0, 1, 0, "R7 program unerased");
    nbusy = 3; run_op(1, 0, 10, "R8 erase with ignored start");
    for (int i = 0; i < BANK; i++) src_mem[i] = 8'(i * 7 + 3);
    nbusy = 0; run_op(0, 1, 0, "R2 immediate ready");
    nbusy = 1; run_op(1, 0, 0, "erase");
    err_byte = 5; err_bits = 8'h10; run_op(0, 1, 0, "R6 program status error");
    err_byte = -1;
    run_op(1, 0, 0, "erase");
    hang_byte = 9; run_op(0, 1, 0, "R5 program hang");
    hang_byte = -1;
    hang_erase = 1; run_op(1, 0, 0, "R5 erase hang");
    hang_erase = 0;
    erase_err_en = 1; err_bits = 8'h20; run_op(1, 0, 0, "R6 erase status error");
    erase_err_en = 0;
    run_op(1, 1, 0, "R8 both starts");

    $display("Result: errors=%0d of %0d checks", nfails, nchecks);
    $finish;
  end
endmodule